// File: doc/BRIEF.md
# Shared Register File Host Bridge

This block connects a host processor bus to a 64-word by 32-bit register file that the host shares with a microcoded coprocessor. The host drives an address strobe, a data strobe, a read/write line and a byte address. An access that falls inside the file's window reaches one word. An access to one dedicated address loads a small control word. The decode result also comes out as a pair of active-low read and write enables.

The file can only be used by one side at a time. A single ownership bit, driven by the microcode, hands it either to the host or to the coprocessor. A host access made while the coprocessor owns the file is not carried out. The coprocessor side reads two operands, on ports A and B, and writes one result on port B, all in the same cycle. The control word tells the sequencer to start, and it selects one of 4 dispatch sets and one of 16 entries within that set. When the coprocessor reports that its routine is done, the bridge raises an interrupt to the host. That interrupt stays up until the host writes the control word again.

Top module: `hsrf_bridge`

## Requirements
- R1: A host access is decoded only while both `hst_astb` and `hst_dstb` are high. Register word n (0..63) sits at byte address `RF_BASE + 4*n`. For such an access, `rf_re_n` goes low when `hst_rnw` is 1 (read) and `rf_we_n` goes low when `hst_rnw` is 0 (write). Both stay high for a misaligned address, an address outside the 256-byte window, or an access with a strobe missing. They are never low together.
- R2: While `own_host` is 1, a host write stores `hst_wdata` into word n at the clock edge. A later host read of word n returns that value on `hst_rdata` in the same cycle as the read.
- R3: While `own_host` is 0, a host read of the file returns 0 and a host write leaves the file unchanged. A dropped write sets `host_err` one clock edge later.
- R4: A host write to `CTRL_ADDR` loads `hst_wdata[6:0]` at the clock edge. Bit 6 drives `seq_go`, bits 5:4 drive `seq_set` and bits 3:0 drive `seq_entry`.
- R5: A one-cycle pulse on `cp_done` sets `irq` at the next edge. `irq` then holds until a host write to `CTRL_ADDR`, which clears it. If `cp_done` and a control write happen in the same cycle, `irq` is set.
- R6: A host write to `CTRL_ADDR` clears `host_err`.
- R7: While `own_host` is 0, `cp_ra_data` and `cp_rb_data` combinationally show the words at `cp_ra_idx` and `cp_rb_idx`. In the same cycle, `cp_wb_en` writes `cp_wb_data` to `cp_wb_idx` at the edge, so a read of that word shows the old value in that cycle and the new value after the edge. A coprocessor write while `own_host` is 1 is ignored.
- R8: Synchronous reset clears every file word, the control word, `irq` and `host_err`.
- R9: A host read of `CTRL_ADDR`, or of any address that is not a file word, returns 0 on `hst_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hst_astb | input | 1 | Host address strobe, active high |
| hst_dstb | input | 1 | Host data strobe, active high |
| hst_rnw | input | 1 | 1 = host read, 0 = host write |
| hst_addr | input | 32 | Host byte address |
| hst_wdata | input | 32 | Host write data |
| hst_rdata | output | 32 | Host read data, combinational |
| rf_we_n | output | 1 | Decoded file write enable, active low |
| rf_re_n | output | 1 | Decoded file read enable, active low |
| own_host | input | 1 | Ownership bit from microcode: 1 = host, 0 = coprocessor |
| cp_ra_idx | input | 6 | Coprocessor read port A word index |
| cp_rb_idx | input | 6 | Coprocessor read port B word index |
| cp_ra_data | output | 32 | Port A read data |
| cp_rb_data | output | 32 | Port B read data |
| cp_wb_en | input | 1 | Port B write enable |
| cp_wb_idx | input | 6 | Port B write word index |
| cp_wb_data | input | 32 | Port B write data |
| cp_done | input | 1 | Routine-complete pulse from the coprocessor |
| seq_go | output | 1 | Start test flag to the sequencer |
| seq_set | output | 2 | Dispatch set select |
| seq_entry | output | 4 | Entry within the dispatch set |
| irq | output | 1 | Completion interrupt to the host |
| host_err | output | 1 | Sticky flag: a host write was dropped |

## Verification
The outputs fall into two timing classes:
- Same cycle as the stimulus: host read data, the two decoded enables and the coprocessor read ports all follow the present inputs and the stored state combinationally.
- One clock edge after the stimulus: file contents, the control fields, `irq` and `host_err`.

The bench drives inputs one time unit after a rising edge. It steps a behavioural model at each rising edge and compares every output at the falling edge. In that way a same-cycle result is compared in the cycle of its stimulus, and a stored result in the cycle after it. The write-then-read collision on one word is checked in both cycles, so the bench sees the old value first and the new value next.

// File: rtl/hsrf_pkg.sv
package hsrf_pkg;

    localparam int CTRL_W = 7;

    typedef struct packed {
        logic       go;
        logic [1:0] set;
        logic [3:0] entry;
    } ctrl_word_t;

    typedef enum logic [2:0] {
        ACC_NONE,
        ACC_RF_RD,
        ACC_RF_WR,
        ACC_CTL_RD,
        ACC_CTL_WR
    } acc_kind_t;

endpackage

// File: rtl/hsrf_decode.sv
module hsrf_decode
    import hsrf_pkg::*;
#(
    parameter int               ADDR_W    = 32,
    parameter int               IDX_W     = 6,
    parameter logic [ADDR_W-1:0] RF_BASE  = 32'hFFFF_0000,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 32'hFFFF_0100
) (
    input  logic              astb,
    input  logic              dstb,
    input  logic              rnw,
    input  logic [ADDR_W-1:0] addr,
    output acc_kind_t         kind,
    output logic [IDX_W-1:0]  idx
);
    localparam int SPAN_LSB = IDX_W + 2;

    logic valid, in_win, ctl_hit;

    always_comb begin
        valid   = astb & dstb;
        in_win  = (addr[ADDR_W-1:SPAN_LSB] == RF_BASE[ADDR_W-1:SPAN_LSB])
                  && (addr[1:0] == 2'b00);
        ctl_hit = (addr == CTRL_ADDR);
        idx     = addr[SPAN_LSB-1:2];
        kind    = ACC_NONE;
        if (valid) begin
            if (in_win)       kind = rnw ? ACC_RF_RD  : ACC_RF_WR;
            else if (ctl_hit) kind = rnw ? ACC_CTL_RD : ACC_CTL_WR;
        end
    end
endmodule

// File: rtl/hsrf_ctrl.sv
module hsrf_ctrl
    import hsrf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ctl_wr,
    input  logic [CTRL_W-1:0] ctl_data,
    input  logic              done,
    input  logic              drop,
    output ctrl_word_t        word,
    output logic              irq,
    output logic              err
);
    always_ff @(posedge clk) begin
        if (rst) begin
            word <= '0;
            irq  <= 1'b0;
            err  <= 1'b0;
        end else begin
            if (ctl_wr) word <= ctrl_word_t'(ctl_data);
            if (done)        irq <= 1'b1;
            else if (ctl_wr) irq <= 1'b0;
            if (drop)        err <= 1'b1;
            else if (ctl_wr) err <= 1'b0;
        end
    end

    // R5
    irq_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (irq && !ctl_wr) |=> irq);
    // R5
    irq_set_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> irq);
    // R3
    err_src_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(err) |-> $past(drop));
    // R4
    ctrl_load_chk: assert property (@(posedge clk) disable iff (rst)
        !ctl_wr |=> $stable(word));
endmodule

// File: rtl/hsrf_mem.sv
module hsrf_mem #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 64,
    parameter int IDX_W  = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_own,
    input  logic              h_we,
    input  logic [IDX_W-1:0]  h_idx,
    input  logic [DATA_W-1:0] h_wdata,
    output logic [DATA_W-1:0] h_rdata,
    input  logic [IDX_W-1:0]  ra_idx,
    input  logic [IDX_W-1:0]  rb_idx,
    output logic [DATA_W-1:0] ra_data,
    output logic [DATA_W-1:0] rb_data,
    input  logic              wb_en,
    input  logic [IDX_W-1:0]  wb_idx,
    input  logic [DATA_W-1:0] wb_data
);
    logic [DATA_W-1:0] mem [DEPTH];
    logic              w_en;
    logic [IDX_W-1:0]  w_idx;
    logic [DATA_W-1:0] w_data;

    always_comb begin
        h_rdata = mem[h_idx];
        ra_data = mem[ra_idx];
        rb_data = mem[rb_idx];
        if (host_own) begin
            w_en = h_we;  w_idx = h_idx;  w_data = h_wdata;
        end else begin
            w_en = wb_en; w_idx = wb_idx; w_data = wb_data;
        end
    end

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_word
            always_ff @(posedge clk) begin
                if (rst)
                    mem[g] <= '0;
                else if (w_en && (w_idx == IDX_W'(g)))
                    mem[g] <= w_data;
            end
        end
    endgenerate

    // R7
    cp_block_chk: assert property (@(posedge clk) disable iff (rst)
        (host_own && wb_en && !h_we) |=> (mem[$past(wb_idx)] == $past(mem[wb_idx])));
    // R3
    host_block_chk: assert property (@(posedge clk) disable iff (rst)
        (!host_own && h_we && !wb_en) |=> (mem[$past(h_idx)] == $past(mem[h_idx])));
endmodule

// File: rtl/hsrf_bridge.sv
module hsrf_bridge
    import hsrf_pkg::*;
#(
    parameter int                DATA_W    = 32,
    parameter int                DEPTH     = 64,
    parameter int                ADDR_W    = 32,
    parameter logic [ADDR_W-1:0] RF_BASE   = 32'hFFFF_0000,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 32'hFFFF_0100
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hst_astb,
    input  logic              hst_dstb,
    input  logic              hst_rnw,
    input  logic [ADDR_W-1:0] hst_addr,
    input  logic [DATA_W-1:0] hst_wdata,
    output logic [DATA_W-1:0] hst_rdata,
    output logic              rf_we_n,
    output logic              rf_re_n,
    input  logic              own_host,
    input  logic [5:0]        cp_ra_idx,
    input  logic [5:0]        cp_rb_idx,
    output logic [DATA_W-1:0] cp_ra_data,
    output logic [DATA_W-1:0] cp_rb_data,
    input  logic              cp_wb_en,
    input  logic [5:0]        cp_wb_idx,
    input  logic [DATA_W-1:0] cp_wb_data,
    input  logic              cp_done,
    output logic              seq_go,
    output logic [1:0]        seq_set,
    output logic [3:0]        seq_entry,
    output logic              irq,
    output logic              host_err
);
    localparam int IDX_W = $clog2(DEPTH);

    acc_kind_t         kind;
    logic [IDX_W-1:0]  h_idx;
    logic [DATA_W-1:0] raw_rdata;
    logic              h_we, drop, ctl_wr;
    ctrl_word_t        cword;

    hsrf_decode #(
        .ADDR_W(ADDR_W), .IDX_W(IDX_W),
        .RF_BASE(RF_BASE), .CTRL_ADDR(CTRL_ADDR)
    ) u_dec (
        .astb(hst_astb), .dstb(hst_dstb), .rnw(hst_rnw),
        .addr(hst_addr), .kind(kind), .idx(h_idx)
    );

    always_comb begin
        rf_re_n   = !(kind == ACC_RF_RD);
        rf_we_n   = !(kind == ACC_RF_WR);
        h_we      = (kind == ACC_RF_WR) && own_host;
        drop      = (kind == ACC_RF_WR) && !own_host;
        ctl_wr    = (kind == ACC_CTL_WR);
        hst_rdata = ((kind == ACC_RF_RD) && own_host) ? raw_rdata : '0;
        seq_go    = cword.go;
        seq_set   = cword.set;
        seq_entry = cword.entry;
    end

    hsrf_mem #(.DATA_W(DATA_W), .DEPTH(DEPTH), .IDX_W(IDX_W)) u_mem (
        .clk(clk), .rst(rst), .host_own(own_host),
        .h_we(h_we), .h_idx(h_idx), .h_wdata(hst_wdata), .h_rdata(raw_rdata),
        .ra_idx(cp_ra_idx[IDX_W-1:0]), .rb_idx(cp_rb_idx[IDX_W-1:0]),
        .ra_data(cp_ra_data), .rb_data(cp_rb_data),
        .wb_en(cp_wb_en), .wb_idx(cp_wb_idx[IDX_W-1:0]), .wb_data(cp_wb_data)
    );

    hsrf_ctrl u_ctl (
        .clk(clk), .rst(rst), .ctl_wr(ctl_wr),
        .ctl_data(hst_wdata[CTRL_W-1:0]), .done(cp_done), .drop(drop),
        .word(cword), .irq(irq), .err(host_err)
    );

    // R1
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(!rf_we_n && !rf_re_n));
    // R3
    rdata_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !own_host |-> (hst_rdata == '0));
    // R1
    strobe_need_chk: assert property (@(posedge clk) disable iff (rst)
        !(hst_astb && hst_dstb) |-> (rf_we_n && rf_re_n));
endmodule

// File: tb/sim_hsrf_bridge.sv
module sim_hsrf_bridge;
    localparam logic [31:0] BASE = 32'hFFFF_0000;
    localparam logic [31:0] CADR = 32'hFFFF_0100;

    logic        clk = 0, rst = 1;
    logic        astb = 0, dstb = 0, rnw = 1, own = 1;
    logic [31:0] addr = 0, wdata = 0;
    logic [5:0]  ra = 0, rb = 0, wbi = 0;
    logic        wbe = 0, done = 0;
    logic [31:0] wbd = 0;
    logic [31:0] rdata, ra_d, rb_d;
    logic        we_n, re_n, go, irq, err;
    logic [1:0]  set;
    logic [3:0]  entry;

    int errors = 0, checks = 0;
    bit chk_en = 0;

    logic [31:0] m_mem [64];
    logic [6:0]  m_ctl;
    logic        m_irq, m_err;

    always #2 clk = ~clk;

    hsrf_bridge u0 (
        .clk(clk), .rst(rst), .hst_astb(astb), .hst_dstb(dstb), .hst_rnw(rnw),
        .hst_addr(addr), .hst_wdata(wdata), .hst_rdata(rdata),
        .rf_we_n(we_n), .rf_re_n(re_n), .own_host(own),
        .cp_ra_idx(ra), .cp_rb_idx(rb), .cp_ra_data(ra_d), .cp_rb_data(rb_d),
        .cp_wb_en(wbe), .cp_wb_idx(wbi), .cp_wb_data(wbd), .cp_done(done),
        .seq_go(go), .seq_set(set), .seq_entry(entry), .irq(irq), .host_err(err)
    );

    function automatic bit is_word(logic [31:0] a);
        return (a >= BASE) && (a < BASE + 32'd256) && (a % 4 == 0);
    endfunction

    // behavioural reference, stepped on each rising edge
    always @(posedge clk) begin
        bit acc;
        acc = astb && dstb;
        if (rst) begin
            foreach (m_mem[i]) m_mem[i] = 0;
            m_ctl = 0; m_irq = 0; m_err = 0;
            chk_en = 1;
        end else begin
            if (acc && !rnw && is_word(addr)) begin
                if (own) m_mem[(addr - BASE) / 4] = wdata;
                else     m_err = 1;
            end
            if (!own && wbe) m_mem[wbi] = wbd;
            if (acc && !rnw && addr == CADR) begin
                m_ctl = wdata[6:0];
                m_irq = 0;
                if (!(acc && !rnw && is_word(addr))) m_err = 0;
            end
            if (done) m_irq = 1;
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (chk_en) begin
            bit acc, hit;
            logic [31:0] e_rd;
            acc  = astb && dstb;
            hit  = acc && is_word(addr);
            e_rd = (hit && rnw && own) ? m_mem[(addr - BASE) / 4] : 32'd0;
            chk("R2/R3/R9 hst_rdata", rdata, e_rd);
            chk("R1 rf_re_n", {31'd0, re_n}, {31'd0, !(hit && rnw)});
            chk("R1 rf_we_n", {31'd0, we_n}, {31'd0, !(hit && !rnw)});
            chk("R7 cp_ra_data", ra_d, m_mem[ra]);
            chk("R7 cp_rb_data", rb_d, m_mem[rb]);
            chk("R4 control word", {25'd0, go, set, entry}, {25'd0, m_ctl});
            chk("R5 irq", {31'd0, irq}, {31'd0, m_irq});
            chk("R3/R6 host_err", {31'd0, err}, {31'd0, m_err});
        end
    end

    task automatic step();
        @(posedge clk); #1;
        astb = 0; dstb = 0; rnw = 1; wbe = 0; done = 0;
    endtask

    task automatic hacc(logic r, logic [31:0] a, logic [31:0] d, logic s1, logic s2);
        @(posedge clk); #1;
        astb = s1; dstb = s2; rnw = r; addr = a; wdata = d; wbe = 0; done = 0;
    endtask

    task automatic cpop(logic [5:0] a, logic [5:0] b, logic we, logic [5:0] wi, logic [31:0] wd);
        @(posedge clk); #1;
        astb = 0; dstb = 0; ra = a; rb = b; wbe = we; wbi = wi; wbd = wd; done = 0;
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;
        // R8 reset state checked on these idle cycles
        step(); step();
        // R2 host writes and readbacks, first and last words
        hacc(0, BASE + 0,   32'hA5A5_0001, 1, 1);
        hacc(0, BASE + 4,   32'h1234_5678, 1, 1);
        hacc(0, BASE + 252, 32'hDEAD_BEEF, 1, 1);
        hacc(0, BASE + 20,  32'h0000_0055, 1, 1);
        hacc(1, BASE + 0,   0, 1, 1);
        hacc(1, BASE + 252, 0, 1, 1);
        hacc(1, BASE + 4,   0, 1, 1);
        // R1 decode corners: misaligned, out of window, one strobe missing
        hacc(1, BASE + 2,   0, 1, 1);
        hacc(0, BASE + 256, 32'hFFFF_FFFF, 1, 1);
        hacc(1, BASE + 4,   0, 1, 0);
        hacc(0, BASE + 4,   32'h0BAD_0BAD, 0, 1);
        hacc(1, BASE + 4,   0, 1, 1);
        // R9 control address read returns zero
        hacc(1, CADR, 0, 1, 1);
        // R4 control load
        hacc(0, CADR, 32'h0000_005A, 1, 1);
        step(); step();
        // R7 coprocessor owns the file
        own = 0;
        cpop(0, 1, 0, 0, 0);
        cpop(63, 5, 1, 5, 32'hCAFE_0005);
        cpop(5, 5, 1, 5, 32'hCAFE_0006);
        cpop(5, 0, 0, 0, 0);
        // R3 host blocked: read gives zero, write dropped and flagged
        hacc(1, BASE + 0, 0, 1, 1);
        hacc(0, BASE + 0, 32'h7777_7777, 1, 1);
        step();
        cpop(0, 5, 0, 0, 0);
        // R5 completion interrupt holds
        @(posedge clk); #1 done = 1;
        step(); step(); step();
        // R5 R6 control write acknowledges
        hacc(0, CADR, 32'h0000_0023, 1, 1);
        step();
        // R5 done and control write together
        @(posedge clk); #1;
        astb = 1; dstb = 1; rnw = 0; addr = CADR; wdata = 32'h0000_0040; done = 1;
        step(); step();
        // R7 coprocessor write ignored while host owns
        own = 1;
        cpop(7, 7, 1, 7, 32'h5555_AAAA);
        cpop(7, 0, 0, 0, 0);
        hacc(1, BASE + 28, 0, 1, 1);
        // R8 reset mid-run clears everything
        @(posedge clk); #1 rst = 1;
        @(posedge clk); #1 rst = 0;
        step();
        cpop(0, 63, 0, 0, 0);
        hacc(1, BASE + 4, 0, 1, 1);
        step(); step();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule